// File: doc/BRIEF.md
# Snooping Cache Line-State Controller

This block keeps the coherence state and tag of every line of one private cache on a shared snooping bus. A parameter selects one of three invalidation protocols: a three-state one (Invalid, Shared, Modified), a four-state one that adds Exclusive, and a five-state one that also adds Owned. The state and tag array is direct-mapped. The block does not hold the line data.

On the processor side the block takes one read or write per accepted request and answers with a response flag that tells whether the line was present. Misses, upgrades and dirty victims become requests on the bus. Each request is held until the bus grants it. A victim that must be written back goes out first, and the fill request follows it.

On the snoop side the block looks at the bus commands issued by other caches. In the same cycle it reports three things: whether it holds the line, whether it will supply the data cache-to-cache, and whether it must flush the line to memory. It then moves the line to its new state at the next clock edge. Four counters on output ports record hits, misses, write-backs and cache-to-cache supplies.

Top module: `coh_line_ctrl`

## Requirements
- R1: The `PROTO` parameter selects the protocol: 0 = three-state, 1 = four-state, 2 = five-state. Line states are encoded I=0, S=1, E=2, O=3, M=4.
  - A read that finds its tag in state S, E, O or M is a hit. So is a write that finds its tag in E or M.
  - A hit is answered with `resp_valid`=1 and `resp_hit`=1 in the cycle after acceptance, with no bus request.
  - A write hit on E leaves the line in M.
  - `resp_core` echoes the `req_core` value of the request.
- R2: A read miss raises `bus_req_valid` with command 0 (read) and the line address. The request is held, with `req_ready` low, until `bus_grant`.
  - In the cycle after the grant, the response has `resp_hit`=0.
  - The line is filled in S under protocol 0. Under protocols 1 and 2 it is filled in E if `bus_shared` was low in the grant cycle, and in S otherwise.
- R3: A write miss issues command 1 (read-for-ownership). The line is filled in M, and the response has `resp_hit`=0.
- R4: A write that finds its line in S or O issues command 2 (upgrade) with no data transfer. The processor stalls until the grant. The line then becomes M, and the response has `resp_hit`=1.
- R5: If a snoop invalidates the line while this cache waits for an upgrade grant, the pending request changes to command 1 at the same line address. The line is still filled in M after the grant.
- R6: A miss whose victim line is in M or O first issues command 3 (write-back) with the victim's address, and only after that grant issues the fill request. A victim in S or E is dropped with no bus traffic.
- R7: A snooped read (command 0) that matches a valid line asserts `snp_has_copy`. The line then moves as follows:
  - M under protocols 0 and 1 asserts `snp_flush` and becomes S.
  - M under protocol 2 becomes O with no flush.
  - O stays O.
  - E and S become S.
- R8: A snooped read-for-ownership (command 1) or upgrade (command 2) that matches a valid line asserts `snp_has_copy` and leaves the line in I. A matching M line under protocols 0 and 1 asserts `snp_flush` on command 1. Command 2 never asserts supply or flush.
- R9: Under protocols 1 and 2, a matching valid line asserts `snp_supply` on commands 0 and 1. Under protocol 0, `snp_supply` is never asserted.
- R10: A snoop whose tag does not match, or that hits a line in I, drives has-copy, supply, flush and `snp_line_state` to 0 and changes no state. A snooped write-back (command 3) asserts no response and changes no state.
- R11: The counters record the following events:
  - `cnt_hit` and `cnt_miss` count accepted requests that hit or miss.
  - `cnt_wb` counts granted write-backs plus snoop flushes.
  - `cnt_c2c` counts snoop cycles with supply asserted.
- R12: After reset every line is I, all counters are 0, `req_ready` is 1, and no response or bus request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address (index in low IDX_W bits) |
| req_core | input | CORE_W | Requesting core identifier |
| req_ready | output | 1 | Controller idle and accepting a request |
| resp_valid | output | 1 | Response for the accepted request |
| resp_hit | output | 1 | Line was present when the request was accepted |
| resp_core | output | CORE_W | Core identifier of the answered request |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus request |
| bus_grant | input | 1 | Bus grants the pending request this cycle |
| bus_shared | input | 1 | Another cache holds the line (valid with the grant) |
| snp_valid | input | 1 | Snooped command from another cache |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_has_copy | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the data cache-to-cache |
| snp_flush | output | 1 | This cache writes the line back to memory |
| snp_line_state | output | 3 | State the snooped line takes (0 if not held) |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |
| cnt_wb | output | CNT_W | Write-back count |
| cnt_c2c | output | CNT_W | Cache-to-cache supply count |

## Verification
The assertions assume that `bus_grant` is raised only while `bus_req_valid` is high. They also assume that no snoop targets the same index as a processor-side array write in the same cycle, since the processor write wins that race. The stimulus follows both rules. It raises the grant only after it has seen a pending request, and it places every snoop in cycles of its own, apart from the processor's fill edge. The one deliberate overlap comes in the upgrade race, where the snoop lands while the upgrade is still waiting and before the grant.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int PROTO_MSI   = 0;
    localparam int PROTO_MESI  = 1;
    localparam int PROTO_MOESI = 2;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_t;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_UPG = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_RESP,
        PS_WB,
        PS_FILL
    } proc_st_t;

    typedef struct packed {
        logic     has_copy;
        logic     supply;
        logic     flush;
        line_st_t next;
    } snp_rsp_t;

    // Line holds data memory does not have.
    function automatic logic is_dirty(input line_st_t s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    // Write may complete locally with no bus traffic.
    function automatic logic write_local(input line_st_t s);
        return (s == ST_M) || (s == ST_E);
    endfunction

    // State a read fill takes.
    function automatic line_st_t read_fill(input int proto, input logic shared);
        if (proto == PROTO_MSI || shared)
            return ST_S;
        return ST_E;
    endfunction

    // Reaction of a held line to a command snooped from another cache.
    function automatic snp_rsp_t snoop_react(input int proto, input logic held,
                                             input bus_cmd_t cmd, input line_st_t cur);
        snp_rsp_t r;
        r.has_copy = 1'b0;
        r.supply   = 1'b0;
        r.flush    = 1'b0;
        r.next     = cur;
        if (held && cmd != BC_WB) begin
            r.has_copy = 1'b1;
            if (cmd == BC_UPG) begin
                r.next = ST_I;
            end else begin
                r.supply = (proto != PROTO_MSI);
                r.flush  = (cur == ST_M) && (proto != PROTO_MOESI);
                if (cmd == BC_RDX)
                    r.next = ST_I;
                else if (cur == ST_M)
                    r.next = (proto == PROTO_MOESI) ? ST_O : ST_S;
                else if (cur == ST_O)
                    r.next = ST_O;
                else
                    r.next = ST_S;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
    import coh_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    // processor-side lookup
    input  logic [IDX_W-1:0] p_idx,
    output line_st_t         p_st,
    output logic [TAG_W-1:0] p_tag,
    // snoop-side lookup
    input  logic [IDX_W-1:0] s_idx,
    output line_st_t         s_st,
    output logic [TAG_W-1:0] s_tag,
    // processor-side write (state and tag)
    input  logic             pw_en,
    input  logic [IDX_W-1:0] pw_idx,
    input  line_st_t         pw_st,
    input  logic [TAG_W-1:0] pw_tag,
    // snoop-side write (state only)
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  line_st_t         sw_st
);

    localparam int LINES = 1 << IDX_W;

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic p_sel;
        logic s_sel;
        assign p_sel = pw_en && (pw_idx == IDX_W'(i));
        assign s_sel = sw_en && (sw_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end else if (p_sel) begin
                st_q[i]  <= pw_st;
                tag_q[i] <= pw_tag;
            end else if (s_sel) begin
                st_q[i]  <= sw_st;
            end
        end
    end

    assign p_st  = st_q[p_idx];
    assign p_tag = tag_q[p_idx];
    assign s_st  = st_q[s_idx];
    assign s_tag = tag_q[s_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int PROTO = PROTO_MOESI,
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output snp_rsp_t         rsp,
    output line_st_t         line_next,
    output logic             upd_en
);

    logic held;

    always_comb begin
        held      = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
        rsp       = snoop_react(PROTO, held, snp_cmd, line_st);
        line_next = held ? rsp.next : ST_I;
        upd_en    = held && (rsp.next != line_st);
    end

endmodule

// File: rtl/coh_proc_fsm.sv
module coh_proc_fsm
    import coh_pkg::*;
#(
    parameter int PROTO  = PROTO_MOESI,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int CORE_W = 2,
    parameter int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] req_core,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [CORE_W-1:0] resp_core,
    output logic              bus_req_valid,
    output bus_cmd_t          bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_shared,
    output logic [IDX_W-1:0]  lk_idx,
    input  line_st_t          lk_st,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_st_t          wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic              ev_hit,
    output logic              ev_miss,
    output logic              ev_wb
);

    proc_st_t          ps_q, ps_d;
    logic              op_write_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [CORE_W-1:0] op_core_q;
    logic              op_hit_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              line_match;
    logic              accept;

    always_comb begin
        cur_addr   = (ps_q == PS_IDLE) ? req_addr : op_addr_q;
        cur_tag    = cur_addr[ADDR_W-1:IDX_W];
        lk_idx     = cur_addr[IDX_W-1:0];
        line_match = (lk_st != ST_I) && (lk_tag == cur_tag);
        accept     = (ps_q == PS_IDLE) && req_valid;
    end

    always_comb begin
        ps_d          = ps_q;
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        bus_req_valid = 1'b0;
        bus_req_cmd   = BC_RD;
        bus_req_addr  = cur_addr;
        wr_en         = 1'b0;
        wr_idx        = lk_idx;
        wr_st         = lk_st;
        wr_tag        = lk_tag;
        ev_hit        = 1'b0;
        ev_miss       = 1'b0;
        ev_wb         = 1'b0;
        unique case (ps_q)
            PS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (line_match) begin
                        ev_hit = 1'b1;
                        if (!req_write || write_local(lk_st)) begin
                            ps_d = PS_RESP;
                            if (req_write && lk_st == ST_E) begin
                                wr_en = 1'b1;
                                wr_st = ST_M;
                            end
                        end else begin
                            ps_d = PS_FILL;
                        end
                    end else begin
                        ev_miss = 1'b1;
                        ps_d    = is_dirty(lk_st) ? PS_WB : PS_FILL;
                    end
                end
            end
            PS_RESP: begin
                resp_valid = 1'b1;
                ps_d       = PS_IDLE;
            end
            PS_WB: begin
                if (is_dirty(lk_st)) begin
                    bus_req_valid = 1'b1;
                    bus_req_cmd   = BC_WB;
                    bus_req_addr  = {lk_tag, lk_idx};
                    if (bus_grant) begin
                        ev_wb = 1'b1;
                        wr_en = 1'b1;
                        wr_st = ST_I;
                        ps_d  = PS_FILL;
                    end
                end else begin
                    // victim lost its dirty data to a snoop while waiting
                    ps_d = PS_FILL;
                end
            end
            PS_FILL: begin
                bus_req_valid = 1'b1;
                if (!op_write_q)
                    bus_req_cmd = BC_RD;
                else if (line_match)
                    bus_req_cmd = BC_UPG;
                else
                    bus_req_cmd = BC_RDX;
                if (bus_grant) begin
                    wr_en  = 1'b1;
                    wr_tag = cur_tag;
                    wr_st  = op_write_q ? ST_M : read_fill(PROTO, bus_shared);
                    ps_d   = PS_RESP;
                end
            end
            default: ps_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q       <= PS_IDLE;
            op_write_q <= 1'b0;
            op_addr_q  <= '0;
            op_core_q  <= '0;
            op_hit_q   <= 1'b0;
        end else begin
            ps_q <= ps_d;
            if (accept) begin
                op_write_q <= req_write;
                op_addr_q  <= req_addr;
                op_core_q  <= req_core;
                op_hit_q   <= line_match;
            end
        end
    end

    assign resp_hit  = op_hit_q;
    assign resp_core = op_core_q;

endmodule

// File: rtl/coh_event_counter.sv
module coh_event_counter #(
    parameter int W     = 16,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count + W'(inc);
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int PROTO  = PROTO_MOESI,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int CORE_W = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] req_core,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [CORE_W-1:0] resp_core,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_has_copy,
    output logic              snp_supply,
    output logic              snp_flush,
    output logic [2:0]        snp_line_state,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_wb,
    output logic [CNT_W-1:0]  cnt_c2c
);

    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int N_CNT  = 4;
    localparam int INC_W  = 2;

    logic [IDX_W-1:0] lk_idx;
    line_st_t         lk_st;
    logic [TAG_W-1:0] lk_tag;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    line_st_t         wr_st;
    logic [TAG_W-1:0] wr_tag;
    logic             ev_hit, ev_miss, ev_wb;
    bus_cmd_t         bus_cmd_e;

    line_st_t         s_st;
    logic [TAG_W-1:0] s_tag;
    snp_rsp_t         s_rsp;
    line_st_t         s_next;
    logic             s_upd;

    coh_proc_fsm #(
        .PROTO (PROTO),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .CORE_W(CORE_W),
        .TAG_W (TAG_W)
    ) u_proc (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_core     (req_core),
        .req_ready    (req_ready),
        .resp_valid   (resp_valid),
        .resp_hit     (resp_hit),
        .resp_core    (resp_core),
        .bus_req_valid(bus_req_valid),
        .bus_req_cmd  (bus_cmd_e),
        .bus_req_addr (bus_req_addr),
        .bus_grant    (bus_grant),
        .bus_shared   (bus_shared),
        .lk_idx       (lk_idx),
        .lk_st        (lk_st),
        .lk_tag       (lk_tag),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_st        (wr_st),
        .wr_tag       (wr_tag),
        .ev_hit       (ev_hit),
        .ev_miss      (ev_miss),
        .ev_wb        (ev_wb)
    );

    assign bus_req_cmd = bus_cmd_e;

    coh_snoop_unit #(
        .PROTO(PROTO),
        .TAG_W(TAG_W)
    ) u_snoop (
        .snp_valid(snp_valid),
        .snp_cmd  (bus_cmd_t'(snp_cmd)),
        .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
        .line_st  (s_st),
        .line_tag (s_tag),
        .rsp      (s_rsp),
        .line_next(s_next),
        .upd_en   (s_upd)
    );

    coh_state_array #(
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .p_idx (lk_idx),
        .p_st  (lk_st),
        .p_tag (lk_tag),
        .s_idx (snp_addr[IDX_W-1:0]),
        .s_st  (s_st),
        .s_tag (s_tag),
        .pw_en (wr_en),
        .pw_idx(wr_idx),
        .pw_st (wr_st),
        .pw_tag(wr_tag),
        .sw_en (s_upd),
        .sw_idx(snp_addr[IDX_W-1:0]),
        .sw_st (s_next)
    );

    assign snp_has_copy   = s_rsp.has_copy;
    assign snp_supply     = s_rsp.supply;
    assign snp_flush      = s_rsp.flush;
    assign snp_line_state = s_next;

    logic [INC_W-1:0] inc_v [N_CNT];
    logic [CNT_W-1:0] cnt_v [N_CNT];

    assign inc_v[0] = {1'b0, ev_hit};
    assign inc_v[1] = {1'b0, ev_miss};
    assign inc_v[2] = {1'b0, ev_wb} + {1'b0, s_rsp.flush};
    assign inc_v[3] = {1'b0, s_rsp.supply};

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        coh_event_counter #(
            .W    (CNT_W),
            .INC_W(INC_W)
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc_v[k]),
            .count(cnt_v[k])
        );
    end

    assign cnt_hit  = cnt_v[0];
    assign cnt_miss = cnt_v[1];
    assign cnt_wb   = cnt_v[2];
    assign cnt_c2c  = cnt_v[3];

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
    parameter int PROTO  = 2,
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_grant,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_has_copy,
    input logic              snp_supply,
    input logic              snp_flush,
    input logic [CNT_W-1:0]  cnt_hit
);

    AST_RESP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);                                        // R1

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_grant && bus_req_cmd == 2'd0)
        |=> (bus_req_valid && bus_req_cmd == 2'd0 && $stable(bus_req_addr))); // R2

    AST_RESP_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_grant && bus_req_cmd != 2'd3)
        |=> (resp_valid && !bus_req_valid));                               // R2

    AST_STALL_ON_BUS: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !req_ready);                                     // R4

    AST_FLUSH_HAS_COPY: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> snp_has_copy);                                       // R7

    AST_OWNED_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && PROTO == 2) |-> !snp_flush);                         // R7

    AST_UPG_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == 2'd2) |-> (!snp_supply && !snp_flush));   // R8

    AST_MSI_NO_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && PROTO == 0) |-> !snp_supply);                        // R9

    AST_SNOOP_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!snp_valid || snp_cmd == 2'd3)
        |-> (!snp_has_copy && !snp_supply && !snp_flush));                 // R10

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        ##1 ((cnt_hit == $past(cnt_hit)) || (cnt_hit == $past(cnt_hit) + 1'b1))); // R11

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(
    .PROTO (PROTO),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .bus_req_valid(bus_req_valid),
    .bus_req_cmd  (bus_req_cmd),
    .bus_req_addr (bus_req_addr),
    .bus_grant    (bus_grant),
    .snp_valid    (snp_valid),
    .snp_cmd      (snp_cmd),
    .snp_has_copy (snp_has_copy),
    .snp_supply   (snp_supply),
    .snp_flush    (snp_flush),
    .cnt_hit      (cnt_hit)
);

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/100ps
module test_coh_line_ctrl;

    localparam real HALF = 2.5;
    localparam int  NP   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(HALF) clk = ~clk;

    logic       req_valid [NP];
    logic       req_write [NP];
    logic [9:0] req_addr  [NP];
    logic [1:0] req_core  [NP];
    logic       req_ready [NP];
    logic       resp_valid[NP];
    logic       resp_hit  [NP];
    logic [1:0] resp_core [NP];
    logic       bus_req_valid[NP];
    logic [1:0] bus_req_cmd  [NP];
    logic [9:0] bus_req_addr [NP];
    logic       bus_grant [NP];
    logic       bus_shared[NP];
    logic       snp_valid [NP];
    logic [1:0] snp_cmd   [NP];
    logic [9:0] snp_addr  [NP];
    logic       snp_has_copy[NP];
    logic       snp_supply  [NP];
    logic       snp_flush   [NP];
    logic [2:0] snp_line_state[NP];
    logic [15:0] cnt_hit [NP];
    logic [15:0] cnt_miss[NP];
    logic [15:0] cnt_wb  [NP];
    logic [15:0] cnt_c2c [NP];

    for (genvar g = 0; g < NP; g++) begin : g_dut
        coh_line_ctrl #(.PROTO(g)) i_coh_line_ctrl (
            .clk(clk), .rst(rst),
            .req_valid(req_valid[g]), .req_write(req_write[g]),
            .req_addr(req_addr[g]), .req_core(req_core[g]),
            .req_ready(req_ready[g]), .resp_valid(resp_valid[g]),
            .resp_hit(resp_hit[g]), .resp_core(resp_core[g]),
            .bus_req_valid(bus_req_valid[g]), .bus_req_cmd(bus_req_cmd[g]),
            .bus_req_addr(bus_req_addr[g]), .bus_grant(bus_grant[g]),
            .bus_shared(bus_shared[g]), .snp_valid(snp_valid[g]),
            .snp_cmd(snp_cmd[g]), .snp_addr(snp_addr[g]),
            .snp_has_copy(snp_has_copy[g]), .snp_supply(snp_supply[g]),
            .snp_flush(snp_flush[g]), .snp_line_state(snp_line_state[g]),
            .cnt_hit(cnt_hit[g]), .cnt_miss(cnt_miss[g]),
            .cnt_wb(cnt_wb[g]), .cnt_c2c(cnt_c2c[g])
        );
    end

    // Reference model: states I=0 S=1 E=2 O=3 M=4
    int mst  [NP][16];
    int mtag [NP][16];
    int m_hit[NP], m_miss[NP], m_wb[NP], m_c2c[NP];
    int checks = 0;
    int errors = 0;

    task automatic chk(input int p, input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s proto=%0d %s: actual=%0d expected=%0d", rq, p, what, act, exp);
        end
    endtask

    // Counters compared against the model on every cycle (R11, R12)
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                chk(p, cnt_hit[p]  == 16'(m_hit[p]),  "R11", "cnt_hit",  cnt_hit[p],  m_hit[p]);
                chk(p, cnt_miss[p] == 16'(m_miss[p]), "R11", "cnt_miss", cnt_miss[p], m_miss[p]);
                chk(p, cnt_wb[p]   == 16'(m_wb[p]),   "R11", "cnt_wb",   cnt_wb[p],   m_wb[p]);
                chk(p, cnt_c2c[p]  == 16'(m_c2c[p]),  "R11", "cnt_c2c",  cnt_c2c[p],  m_c2c[p]);
            end
        end
    end

    // Called at a negedge with a request expected on the bus; leaves at the negedge after the grant.
    task automatic grant_phase(input int p, input int cmd, input int addr, input int waits,
                               input bit shr, input string rq);
        chk(p, bus_req_valid[p] == 1'b1, rq, "bus_req_valid", bus_req_valid[p], 1);
        chk(p, bus_req_cmd[p] == 2'(cmd), rq, "bus_req_cmd", bus_req_cmd[p], cmd);
        chk(p, bus_req_addr[p] == 10'(addr), rq, "bus_req_addr", bus_req_addr[p], addr);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk(p, bus_req_valid[p] && bus_req_cmd[p] == 2'(cmd), rq, "request held", bus_req_cmd[p], cmd);
            chk(p, req_ready[p] == 1'b0, "R4", "stall while waiting", req_ready[p], 0);
        end
        bus_grant[p]  = 1'b1;
        bus_shared[p] = shr;
        @(posedge clk);
        if (cmd == 3) m_wb[p]++;
        @(negedge clk);
        bus_grant[p]  = 1'b0;
        bus_shared[p] = 1'b0;
    endtask

    task automatic do_req(input int p, input bit wr, input int addr, input bit shr, input int waits);
        int  idx = addr % 16;
        int  tg  = addr / 16;
        int  st  = mst[p][idx];
        bit  hit = (st != 0) && (mtag[p][idx] == tg);
        int  core = addr % 4;
        string rq = !hit ? (wr ? "R3" : "R2") : "R1";
        @(negedge clk);
        chk(p, req_ready[p] == 1'b1, "R1", "ready before request", req_ready[p], 1);
        req_valid[p] = 1'b1; req_write[p] = wr; req_addr[p] = 10'(addr); req_core[p] = 2'(core);
        @(posedge clk);
        if (hit) m_hit[p]++; else m_miss[p]++;
        @(negedge clk);
        req_valid[p] = 1'b0;
        if (hit && (!wr || st == 4 || st == 2)) begin
            chk(p, resp_valid[p] == 1'b1, "R1", "hit resp_valid", resp_valid[p], 1);
            chk(p, resp_hit[p] == 1'b1, "R1", "hit resp_hit", resp_hit[p], 1);
            chk(p, bus_req_valid[p] == 1'b0, "R1", "hit no bus", bus_req_valid[p], 0);
            chk(p, resp_core[p] == 2'(core), "R1", "resp_core", resp_core[p], core);
            if (wr) mst[p][idx] = 4;
            return;
        end
        if (!hit && (st == 4 || st == 3))
            grant_phase(p, 3, mtag[p][idx] * 16 + idx, waits, 1'b0, "R6");
        else if (!hit && st != 0)
            chk(p, !(bus_req_valid[p] && bus_req_cmd[p] == 2'd3), "R6", "silent victim", bus_req_cmd[p], 0);
        grant_phase(p, !wr ? 0 : (hit ? 2 : 1), addr, waits, shr, hit ? "R4" : rq);
        mtag[p][idx] = tg;
        mst[p][idx]  = wr ? 4 : ((p == 0 || shr) ? 1 : 2);
        chk(p, resp_valid[p] == 1'b1, rq, "resp_valid after grant", resp_valid[p], 1);
        chk(p, resp_hit[p] == hit, hit ? "R4" : rq, "resp_hit after grant", resp_hit[p], hit);
    endtask

    task automatic exp_snoop(input int p, input int cmd, input int st, input bit held,
                             output bit hc, output bit sp, output bit fl, output int nst);
        hc = 0; sp = 0; fl = 0; nst = held ? st : 0;
        if (held && cmd != 3) begin
            hc = 1;
            if (cmd == 2) begin
                nst = 0;
            end else begin
                sp = (p != 0);
                fl = (st == 4) && (p != 2);
                if (cmd == 1)      nst = 0;
                else if (st == 4)  nst = (p == 2) ? 3 : 1;
                else if (st == 3)  nst = 3;
                else               nst = 1;
            end
        end
    endtask

    task automatic do_snoop(input int p, input int cmd, input int addr, input string rq);
        int idx = addr % 16;
        int st  = mst[p][idx];
        bit held = (st != 0) && (mtag[p][idx] == addr / 16);
        bit hc, sp, fl;
        int nst;
        exp_snoop(p, cmd, st, held, hc, sp, fl, nst);
        @(negedge clk);
        snp_valid[p] = 1'b1; snp_cmd[p] = 2'(cmd); snp_addr[p] = 10'(addr);
        #1;
        chk(p, snp_has_copy[p] == hc, rq, "snp_has_copy", snp_has_copy[p], hc);
        chk(p, snp_supply[p] == sp, hc ? "R9" : rq, "snp_supply", snp_supply[p], sp);
        chk(p, snp_flush[p] == fl, rq, "snp_flush", snp_flush[p], fl);
        chk(p, snp_line_state[p] == 3'(nst), rq, "snp_line_state", snp_line_state[p], nst);
        @(posedge clk);
        if (held) mst[p][idx] = nst;
        if (sp) m_c2c[p]++;
        if (fl) m_wb[p]++;
        @(negedge clk);
        snp_valid[p] = 1'b0;
    endtask

    // Upgrade pending while another cache invalidates the line (R5)
    task automatic do_race(input int p, input int addr);
        int idx = addr % 16;
        @(negedge clk);
        req_valid[p] = 1'b1; req_write[p] = 1'b1; req_addr[p] = 10'(addr); req_core[p] = 2'(addr % 4);
        @(posedge clk);
        m_hit[p]++;
        @(negedge clk);
        req_valid[p] = 1'b0;
        chk(p, bus_req_valid[p] && bus_req_cmd[p] == 2'd2, "R4", "upgrade cmd", bus_req_cmd[p], 2);
        snp_valid[p] = 1'b1; snp_cmd[p] = 2'd2; snp_addr[p] = 10'(addr);
        #1;
        chk(p, snp_has_copy[p] == 1'b1, "R8", "race has_copy", snp_has_copy[p], 1);
        @(posedge clk);
        mst[p][idx] = 0;
        @(negedge clk);
        snp_valid[p] = 1'b0;
        grant_phase(p, 1, addr, 1, 1'b0, "R5");
        mst[p][idx] = 4;
        chk(p, resp_valid[p] == 1'b1, "R5", "race resp_valid", resp_valid[p], 1);
        chk(p, resp_hit[p] == 1'b1, "R5", "race resp_hit", resp_hit[p], 1);
    endtask

    task automatic run_proto(input int p);
        // tag*16 + index line addresses
        int a  = 1*16 + 1;
        int b  = 2*16 + 1;
        int c  = 1*16 + 2;
        int cx = 5*16 + 2;
        int d  = 1*16 + 3;
        int e  = 1*16 + 4;
        int f  = 3*16 + 4;
        do_snoop(p, 0, a, "R12");         // empty array after reset
        do_req(p, 0, a, 1'b0, 0);         // R2 fill E or S
        do_req(p, 0, a, 1'b0, 0);         // R1 read hit
        do_req(p, 1, a, 1'b0, 1);         // R1 silent E->M, or R4 upgrade
        do_snoop(p, 0, a, "R7");          // M snooped by read
        do_req(p, 0, a, 1'b0, 0);         // R1 read hit in S or O
        do_req(p, 1, a, 1'b0, 2);         // R4 upgrade from S or O
        do_snoop(p, 0, a, "R7");
        do_req(p, 0, b, 1'b1, 1);         // R6 victim S (silent) or O (write-back)
        do_snoop(p, 1, b, "R8");          // read-for-ownership on S
        do_req(p, 1, c, 1'b0, 0);         // R3 write miss
        do_snoop(p, 2, cx, "R10");        // tag mismatch
        do_snoop(p, 3, c, "R10");         // snooped write-back ignored
        do_req(p, 1, c, 1'b0, 0);         // R10 line still M: silent write hit
        do_snoop(p, 1, c, "R8");          // M invalidated by RDX
        do_req(p, 0, d, 1'b1, 0);         // R2 shared fill
        do_race(p, d);                    // R5
        do_req(p, 1, d, 1'b0, 0);         // R5 line now M
        do_req(p, 1, e, 1'b0, 0);         // R3
        do_req(p, 0, f, 1'b0, 1);         // R6 M victim written back
        do_snoop(p, 2, f, "R8");          // upgrade never supplies
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            req_valid[p] = 0; req_write[p] = 0; req_addr[p] = '0; req_core[p] = '0;
            bus_grant[p] = 0; bus_shared[p] = 0;
            snp_valid[p] = 0; snp_cmd[p] = '0; snp_addr[p] = '0;
            m_hit[p] = 0; m_miss[p] = 0; m_wb[p] = 0; m_c2c[p] = 0;
            for (int i = 0; i < 16; i++) begin
                mst[p][i] = 0; mtag[p][i] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(p, req_ready[p] == 1'b1, "R12", "reset ready", req_ready[p], 1);
            chk(p, resp_valid[p] == 1'b0, "R12", "reset resp_valid", resp_valid[p], 0);
            chk(p, bus_req_valid[p] == 1'b0, "R12", "reset bus_req_valid", bus_req_valid[p], 0);
        end
        for (int p = 0; p < NP; p++) run_proto(p);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(HALF * 2 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule